// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular list of transmit descriptors in memory and turns each descriptor that software has handed over into one segment request on a streaming output. Every descriptor is four 32-bit words: a control word, two words for a 64-bit buffer address, and a word with two lengths. The walker reads the words one at a time through a simple memory port. It presents the segment (address, byte length, TCP segment length, frame delimiters, offload requests and two queue identifiers) with a valid/ready handshake. It then writes the control word back with the ownership bit cleared and pulses a completion strobe that carries the descriptor index.

There is no ring-length register. A flag in the control word marks the last slot, and the walker then returns to the ring base. One frame may cover several descriptors, opened by a first-segment flag and closed by a last-segment flag. When the walker reads a descriptor that software has not handed over, it goes idle. A kick strobe restarts it at that same descriptor. A segment that arrives outside an open frame is discarded. If such a segment also claims to end a frame, a sticky error flag is raised.

Top module: `txr_walker`

## Requirements
- R1: After reset the block makes no memory access and shows no segment, completion or error. It stays idle until `kick` is pulsed. The first descriptor fetched after reset is at `ring_base`.
- R2: Descriptor i lies at `ring_base + 16*i`, and word k of it lies at offset 4*k. The segment address is {word1, word2}, `seg_len` is word3[15:0] and `seg_tcp_len` is word3[31:16]. The port never reads and writes in the same cycle.
- R3: Control bit 31 set means the engine owns the descriptor. If a fetched control word has bit 31 clear, the block emits nothing and writes nothing for it. It goes idle and, on the next `kick`, fetches that same descriptor again.
- R4: Once a descriptor has been consumed, its control word is written back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R5: If control bit 30 is set in a consumed descriptor, the next fetch is at `ring_base` (index 0). Otherwise the index advances by one, modulo 2^IDX_W.
- R6: Control bit 9 (first segment) and bit 8 (last segment) appear on `seg_first` and `seg_last`.
- R7: `seg_csum` (control bit 7) and `seg_tso` (control bit 6) are passed on only with a segment that has bit 9 set, and are 0 on every other segment.
- R8: Control bits 29:24 appear on `seg_dst_q` and bits 20:16 on `seg_src_q`, unchanged.
- R9: A descriptor without bit 9 that arrives while no frame is open is dropped: no segment is emitted, but it is still written back. If it carries bit 8, `proto_err` is set, and only reset clears it.
- R10: `done_valid` pulses for one cycle, in the cycle after each write-back, with the descriptor's index on `done_idx`. In that same cycle the read of the next descriptor's control word is issued.
- R11: While `seg_valid` is high and `seg_ready` is low, the segment fields hold steady. The write-back happens only after the segment is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| kick | input | 1 | Start or resume strobe |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address for read or write |
| mem_wdata | output | 32 | Write data (control word write-back) |
| mem_rdata | input | 32 | Read data, RD_LAT cycles after the request |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Segment request accepted |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 16 | Segment byte length |
| seg_tcp_len | output | 16 | TCP segment length |
| seg_first | output | 1 | First segment of frame |
| seg_last | output | 1 | Last segment of frame |
| seg_csum | output | 1 | Checksum offload request (first segment only) |
| seg_tso | output | 1 | Segmentation offload request (first segment only) |
| seg_dst_q | output | 6 | Destination queue identifier |
| seg_src_q | output | 5 | Source queue identifier |
| done_valid | output | 1 | Completion pulse |
| done_idx | output | IDX_W | Index of the completed descriptor |
| proto_err | output | 1 | Sticky frame-delimiter error |

## Verification
The completion pulse for one descriptor and the read request for the next one fall in the same cycle. The hard case is a descriptor with the end-of-array flag, where that read must already point at the ring base. Directed rings that wrap, and random rings with the end flag scattered, provoke this. On every completion pulse the bench checks the reported index and also checks that a read is issued in that cycle at the address its own model predicts. Random backpressure on `seg_ready` makes sure the write-back and completion never come forward into a cycle in which the segment is still stalled.

// File: rtl/txr_pkg.sv
package txr_pkg;
   // control word bit positions (the host side decodes these)
   localparam int unsigned OWN_B  = 31;
   localparam int unsigned END_B  = 30;
   localparam int unsigned DQ_LO  = 24;
   localparam int unsigned DQ_W   = 6;
   localparam int unsigned SQ_LO  = 16;
   localparam int unsigned SQ_W   = 5;
   localparam int unsigned FST_B  = 9;
   localparam int unsigned LST_B  = 8;
   localparam int unsigned CSUM_B = 7;
   localparam int unsigned TSO_B  = 6;

   localparam int unsigned WORD_BITS  = 32;
   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned DESC_SH    = 4;   // log2 of descriptor bytes
   localparam int unsigned WORD_SH    = 2;   // log2 of word bytes

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WT,
      ST_DEC,
      ST_SEND,
      ST_WB
   } walk_st_e;
endpackage

// File: rtl/txr_rd_pipe.sv
module txr_rd_pipe #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic vld
);
   logic [LAT-1:0] sh_q;

   generate
      if (LAT < 1 || LAT > 8) begin : g_bad_lat
         $error("txr_rd_pipe: LAT must be 1..8");
      end
      if (LAT == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= issue;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[LAT-2:0], issue};
         end
      end
   endgenerate

   assign vld = sh_q[LAT-1];
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   input  logic              wrap,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] desc_addr
);
   import txr_pkg::*;

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx_q <= '0;
      else if (adv) idx_q <= wrap ? '0 : idx_q + 1'b1;
   end

   assign idx       = idx_q;
   assign desc_addr = base + (ADDR_W'(idx_q) << DESC_SH);
endmodule

// File: rtl/txr_frame_track.sv
module txr_frame_track (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic first,
   input  logic last,
   output logic emit,
   output logic err
);
   logic open_q;
   logic err_q;

   assign emit = first | open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (step) begin
         if (first)       open_q <= !last;
         else if (open_q) open_q <= !last;
         else if (last)   err_q  <= 1'b1;
      end
   end

   assign err = err_q;
endmodule

// File: rtl/txr_walker.sv
module txr_walker #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              kick,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [63:0]       seg_addr,
   output logic [15:0]       seg_len,
   output logic [15:0]       seg_tcp_len,
   output logic              seg_first,
   output logic              seg_last,
   output logic              seg_csum,
   output logic              seg_tso,
   output logic [5:0]        seg_dst_q,
   output logic [4:0]        seg_src_q,
   output logic              done_valid,
   output logic [IDX_W-1:0]  done_idx,
   output logic              proto_err
);
   import txr_pkg::*;

   localparam int WI_W    = $clog2(DESC_WORDS);
   localparam int LAST_WI = DESC_WORDS - 1;

   generate
      if (ADDR_W < IDX_W + DESC_SH) begin : g_bad_aw
         $error("txr_walker: ADDR_W too small for IDX_W descriptors");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("txr_walker: IDX_W must be 1..16");
      end
   endgenerate

   walk_st_e                             st_q;
   logic [WI_W-1:0]                      wi_q;
   logic [DESC_WORDS-1:0][WORD_BITS-1:0] words_q;
   logic                                 done_q;
   logic [IDX_W-1:0]                     done_idx_q;

   logic              rd_vld;
   logic              emit;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] desc_addr;
   logic              in_rd, in_wb, in_dec, in_send;

   assign in_rd   = (st_q == ST_RD);
   assign in_wb   = (st_q == ST_WB);
   assign in_dec  = (st_q == ST_DEC);
   assign in_send = (st_q == ST_SEND);

   txr_rd_pipe #(.LAT(RD_LAT)) u_rd_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (in_rd),
      .vld   (rd_vld)
   );

   txr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .base      (ring_base),
      .adv       (in_wb),
      .wrap      (words_q[0][END_B]),
      .idx       (idx),
      .desc_addr (desc_addr)
   );

   txr_frame_track u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (in_dec),
      .first (words_q[0][FST_B]),
      .last  (words_q[0][LST_B]),
      .emit  (emit),
      .err   (proto_err)
   );

   // sequencer: one word per read, then decide, send, write back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         wi_q       <= '0;
         words_q    <= '0;
         done_q     <= 1'b0;
         done_idx_q <= '0;
      end else begin
         done_q <= in_wb;
         if (in_wb) done_idx_q <= idx;
         unique case (st_q)
            ST_IDLE: if (kick) begin
               st_q <= ST_RD;
               wi_q <= '0;
            end
            ST_RD: st_q <= ST_WT;
            ST_WT: if (rd_vld) begin
               words_q[wi_q] <= mem_rdata;
               if (wi_q == '0 && !mem_rdata[OWN_B]) st_q <= ST_IDLE;
               else if (wi_q == WI_W'(LAST_WI))     st_q <= ST_DEC;
               else begin
                  wi_q <= wi_q + 1'b1;
                  st_q <= ST_RD;
               end
            end
            ST_DEC:  st_q <= emit ? ST_SEND : ST_WB;
            ST_SEND: if (seg_ready) st_q <= ST_WB;
            ST_WB: begin
               st_q <= ST_RD;
               wi_q <= '0;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_en = in_rd;
   assign mem_wr_en = in_wb;
   assign mem_addr  = in_wb ? desc_addr
                            : desc_addr + (ADDR_W'(wi_q) << WORD_SH);
   assign mem_wdata = words_q[0] & ~(32'd1 << OWN_B);

   assign seg_valid   = in_send;
   assign seg_addr    = {words_q[1], words_q[2]};
   assign seg_len     = words_q[3][15:0];
   assign seg_tcp_len = words_q[3][31:16];
   assign seg_first   = words_q[0][FST_B];
   assign seg_last    = words_q[0][LST_B];
   assign seg_csum    = words_q[0][FST_B] & words_q[0][CSUM_B];
   assign seg_tso     = words_q[0][FST_B] & words_q[0][TSO_B];
   assign seg_dst_q   = words_q[0][DQ_LO +: DQ_W];
   assign seg_src_q   = words_q[0][SQ_LO +: SQ_W];

   assign done_valid = done_q;
   assign done_idx   = done_idx_q;
endmodule

// File: rtl/txr_walker_chk.sv
module txr_walker_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ring_base,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [31:0]       mem_wdata,
   input logic              seg_valid,
   input logic              seg_ready,
   input logic [63:0]       seg_addr,
   input logic [15:0]       seg_len,
   input logic              seg_first,
   input logic              seg_csum,
   input logic              seg_tso,
   input logic              done_valid,
   input logic              proto_err
);
   assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   assert_wb_own_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !mem_wdata[31]);

   assert_wrap_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && mem_wdata[30]) |=> (mem_rd_en && mem_addr == ring_base));

   assert_offload_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_first) |-> (!seg_csum && !seg_tso));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   assert_done_follows_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> done_valid);

   assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(mem_wr_en));

   assert_done_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> mem_rd_en);

   assert_seg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

   assert_wb_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> !mem_wr_en);
endmodule

bind txr_walker txr_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ring_base  (ring_base),
   .mem_addr   (mem_addr),
   .mem_rd_en  (mem_rd_en),
   .mem_wr_en  (mem_wr_en),
   .mem_wdata  (mem_wdata),
   .seg_valid  (seg_valid),
   .seg_ready  (seg_ready),
   .seg_addr   (seg_addr),
   .seg_len    (seg_len),
   .seg_first  (seg_first),
   .seg_csum   (seg_csum),
   .seg_tso    (seg_tso),
   .done_valid (done_valid),
   .proto_err  (proto_err)
);

// File: tb/tb_txr_walker.sv
`timescale 1ns/1ps
module tb_txr_walker;
   localparam int          MEMW = 128;
   localparam logic [31:0] BASE = 32'h100;
   localparam int          SLOT0 = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick = 1'b0;
   logic        seg_ready = 1'b1;
   logic [31:0] mem_rdata = '0;
   logic        mem_rd_en, mem_wr_en;
   logic [31:0] mem_addr, mem_wdata;
   logic        seg_valid, seg_first, seg_last, seg_csum, seg_tso;
   logic [63:0] seg_addr;
   logic [15:0] seg_len, seg_tcp_len;
   logic [5:0]  seg_dst_q;
   logic [4:0]  seg_src_q;
   logic        done_valid, proto_err;
   logic [3:0]  done_idx;

   always #2.5 clk = ~clk;

   txr_walker #(.ADDR_W(32), .IDX_W(4), .RD_LAT(1)) dut (
      .clk(clk), .rst_n(rst_n), .ring_base(BASE), .kick(kick),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
      .seg_len(seg_len), .seg_tcp_len(seg_tcp_len), .seg_first(seg_first),
      .seg_last(seg_last), .seg_csum(seg_csum), .seg_tso(seg_tso),
      .seg_dst_q(seg_dst_q), .seg_src_q(seg_src_q),
      .done_valid(done_valid), .done_idx(done_idx), .proto_err(proto_err)
   );

   typedef struct packed {
      logic [63:0] addr;
      logic [15:0] len, tcp;
      logic        fst, lst, csum, tso;
      logic [5:0]  dq;
      logic [4:0]  sq;
   } seg_t;

   typedef struct packed {
      logic [31:0] addr, wdata, next;
      logic [3:0]  idx;
   } wb_t;

   logic [31:0] mem [MEMW];
   seg_t exp_seg [$];
   wb_t  exp_wb [$];
   int   checks = 0, errors = 0, cyc = 0, ready_pct = 100, seg_seen = 0;
   logic [3:0] m_idx = '0;
   bit   m_open = 0, m_err = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model, one-cycle read latency
   always @(posedge clk) begin
      int wi;
      wi = int'(mem_addr >> 2) % MEMW;
      if (mem_rd_en) mem_rdata <= mem[wi];
      if (mem_wr_en) mem[wi] = mem_wdata;
   end

   always @(posedge clk) begin
      #1;
      seg_ready = (($urandom % 100) < ready_pct);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // monitor
   bit          stall_q = 0, pend_done = 0;
   logic [63:0] stall_addr;
   logic [15:0] stall_len;
   wb_t         last_wb;
   seg_t        ms;
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_q) begin
            chk("R11 valid held under stall", seg_valid, 1);
            chk("R11 address held under stall", seg_addr, stall_addr);
            chk("R11 length held under stall", seg_len, stall_len);
            chk("R11 no write-back while stalled", mem_wr_en, 0);
         end
         stall_q = seg_valid && !seg_ready;
         stall_addr = seg_addr;
         stall_len = seg_len;
         if (seg_valid && seg_ready) begin
            seg_seen++;
            if (exp_seg.size() == 0) chk("R9 unexpected segment", 1, 0);
            else begin
               ms = exp_seg.pop_front();
               chk("R2 segment address", seg_addr, ms.addr);
               chk("R2 segment lengths", {seg_tcp_len, seg_len}, {ms.tcp, ms.len});
               chk("R6 first/last flags", {seg_first, seg_last}, {ms.fst, ms.lst});
               chk("R7 offload flags", {seg_csum, seg_tso}, {ms.csum, ms.tso});
               chk("R8 queue ids", {seg_dst_q, seg_src_q}, {ms.dq, ms.sq});
            end
         end
         if (mem_wr_en) begin
            if (exp_wb.size() == 0) chk("R3 unexpected write-back", 1, 0);
            else begin
               last_wb = exp_wb.pop_front();
               chk("R4 write-back address", mem_addr, last_wb.addr);
               chk("R4 write-back data", mem_wdata, last_wb.wdata);
               pend_done = 1;
            end
         end else if (done_valid) begin
            chk("R10 completion follows a write-back", pend_done, 1);
            chk("R10 completion index", done_idx, last_wb.idx);
            chk("R10 next fetch issued with completion", mem_rd_en, 1);
            chk("R5 next fetch address", mem_addr, last_wb.next);
            pend_done = 0;
         end
      end else stall_q = 0;
   end

   function automatic logic [31:0] mk_w0(bit own, bit eod, bit fst, bit lst,
                                         bit csum, bit tso, logic [5:0] dq, logic [4:0] sq);
      logic [31:0] w;
      w = $urandom;
      w[31] = own; w[30] = eod; w[29:24] = dq; w[20:16] = sq;
      w[9] = fst; w[8] = lst; w[7] = csum; w[6] = tso;
      return w;
   endfunction

   task automatic put_desc(input int slot, input logic [31:0] w0);
      mem[SLOT0 + slot*4]     = w0;
      mem[SLOT0 + slot*4 + 1] = $urandom;
      mem[SLOT0 + slot*4 + 2] = $urandom;
      mem[SLOT0 + slot*4 + 3] = $urandom;
   endtask

   // reference walk over a snapshot of memory
   task automatic plan_walk();
      logic [31:0] snap [MEMW];
      for (int i = 0; i < MEMW; i++) snap[i] = mem[i];
      for (int g = 0; g < 40; g++) begin
         logic [31:0] a, w0;
         int   wi;
         seg_t s;
         wb_t  b;
         a  = BASE + 32'(m_idx) * 32'd16;
         wi = int'(a >> 2) % MEMW;
         w0 = snap[wi];
         if (!w0[31]) break;
         if (w0[9] || m_open) begin
            s.addr = {snap[wi+1], snap[wi+2]};
            s.len  = snap[wi+3][15:0];
            s.tcp  = snap[wi+3][31:16];
            s.fst  = w0[9];  s.lst = w0[8];
            s.csum = w0[9] & w0[7];
            s.tso  = w0[9] & w0[6];
            s.dq   = w0[29:24]; s.sq = w0[20:16];
            exp_seg.push_back(s);
         end
         if (w0[9])       m_open = !w0[8];
         else if (m_open) m_open = !w0[8];
         else if (w0[8])  m_err = 1;
         b.addr  = a;
         b.wdata = w0 & 32'h7fff_ffff;
         b.idx   = m_idx;
         snap[wi] = b.wdata;
         m_idx   = w0[30] ? 4'd0 : m_idx + 4'd1;
         b.next  = BASE + 32'(m_idx) * 32'd16;
         exp_wb.push_back(b);
      end
   endtask

   task automatic run_kick();
      int n, rd_cnt;
      plan_walk();
      @(posedge clk); #1 kick = 1;
      @(posedge clk); #1 kick = 0;
      n = 0;
      while ((exp_seg.size() != 0 || exp_wb.size() != 0 || pend_done) && n < 20000) begin
         @(negedge clk); n++;
      end
      repeat (20) @(negedge clk);
      chk("R3 walk stopped with all write-backs seen", exp_wb.size(), 0);
      rd_cnt = 0;
      repeat (10) begin @(negedge clk); if (mem_rd_en) rd_cnt++; end
      chk("R3 idle after unowned descriptor", rd_cnt, 0);
      chk("R9 error flag matches model", proto_err, m_err);
   endtask

   task automatic do_reset();
      rst_n = 0;
      m_idx = '0; m_open = 0; m_err = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
   endtask

   initial begin
      int seed_v, rd_cnt, base_seen;
      seed_v = $urandom(32'h5eed_0042);
      for (int i = 0; i < MEMW; i++) mem[i] = '0;
      do_reset();

      // R1: reset state and no activity without a kick
      @(negedge clk);
      chk("R1 reset seg_valid", seg_valid, 0);
      chk("R1 reset done_valid", done_valid, 0);
      chk("R1 reset proto_err", proto_err, 0);
      chk("R1 reset memory idle", {mem_rd_en, mem_wr_en}, 0);
      for (int k = 0; k < 4; k++) put_desc(k, mk_w0(1, 0, 1, 1, 0, 0, 6'(k), 5'(k)));
      rd_cnt = 0;
      repeat (20) begin @(negedge clk); if (mem_rd_en || mem_wr_en) rd_cnt++; end
      chk("R1 no access before kick", rd_cnt, 0);

      // R1/R5/R7: four-descriptor ring, wrap onto a cleared slot 0
      put_desc(0, mk_w0(1, 0, 1, 1, 1, 0, 6'h11, 5'h02));
      put_desc(1, mk_w0(1, 0, 1, 0, 0, 1, 6'h22, 5'h04));
      put_desc(2, mk_w0(1, 0, 0, 0, 1, 1, 6'h33, 5'h08));
      put_desc(3, mk_w0(1, 1, 0, 1, 0, 0, 6'h3f, 5'h1f));
      base_seen = 0;
      fork
         begin
            @(posedge clk);
            while (!mem_rd_en) @(posedge clk);
            #0.5 base_seen = (mem_addr == BASE);
         end
      join_none
      seg_seen = 0;
      run_kick();
      chk("R1 first fetch at ring base", base_seen, 1);
      chk("R2 segment count on directed ring", seg_seen, 4);
      for (int k = 0; k < 4; k++)
         chk("R4 ownership cleared in memory", mem[SLOT0 + k*4][31], 0);

      // R3: resume at the stopped descriptor (slot 0)
      put_desc(0, mk_w0(1, 0, 1, 1, 0, 1, 6'h05, 5'h05));
      seg_seen = 0;
      run_kick();
      chk("R3 resume emits one segment", seg_seen, 1);

      // R9: stray last segment and stray middle segment are dropped
      chk("R9 error clear before stray segment", proto_err, 0);
      put_desc(1, mk_w0(1, 0, 0, 1, 1, 1, 6'h01, 5'h01));
      put_desc(2, mk_w0(1, 0, 0, 0, 0, 0, 6'h02, 5'h02));
      put_desc(3, mk_w0(1, 1, 1, 1, 0, 0, 6'h03, 5'h03));
      seg_seen = 0;
      run_kick();
      chk("R9 only the well-formed segment emitted", seg_seen, 1);
      chk("R9 sticky error raised", proto_err, 1);
      chk("R4 dropped descriptor still returned", mem[SLOT0 + 4][31], 0);

      // random rings with backpressure
      for (int r = 0; r < 24; r++) begin
         ready_pct = (r % 3 == 0) ? 100 : 55;
         for (int k = 0; k < 16; k++) begin
            logic [31:0] w0;
            w0 = $urandom;
            w0[31] = (($urandom % 5) != 0);
            w0[30] = (($urandom % 5) == 0);
            put_desc(k, w0);
         end
         run_kick();
      end
      ready_pct = 100;

      // R9: reset clears the sticky error
      do_reset();
      @(negedge clk);
      chk("R9 error cleared by reset", proto_err, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule